// File: doc/BRIEF.md
# Comparator-Based Memory Map Decoder

This block sorts every 16-bit processor address into one of three regions by comparing the upper address byte with an 8-bit base value, normally set by board switches. An upper byte equal to the base selects a 256-byte I/O page. Anything above the base selects the on-board 4K ROM. Anything below it selects external RAM. The ROM window is not fixed: it always starts one page above the I/O page, so moving the base down enlarges the ROM region and moving it up shrinks it. The ROM still sees the low 12 address bits, so with a high base only the top part of the ROM image can be reached.

The low address byte is passed on as a port number, with read and write strobes, for I/O-page accesses. A two-bit control register sits at one port number in the I/O page. Bit 0 switches the ROM out, so that addresses above the base fall through to RAM. Bit 1 picks which 4K half of an 8K ROM device is addressed.

Top module: `mem_region_decode`

## Requirements
- R1: While `addr_valid` is high and `addr[15:8]` equals `io_base`, `io_sel` is asserted.
- R2: While `addr_valid` is high, the ROM is enabled and `addr[15:8]` is strictly greater than `io_base`, `rom_sel` is asserted.
- R3: While `addr_valid` is high and `addr[15:8]` is less than `io_base`, `ram_sel` is asserted.
- R4: While `addr_valid` is high, exactly one of `io_sel`, `rom_sel` and `ram_sel` is high. While it is low, all three are low.
- R5: `rom_addr[11:0]` equals `addr[11:0]`. For a base of 0xF8, 0xF800–0xF8FF is I/O and 0xF900–0xFFFF is ROM at physical 0x900–0xFFF.
- R6: A base of 0x00 decodes 0x0000–0x00FF as I/O and 0x0100–0xFFFF as ROM. A base of 0xFF leaves no ROM region: 0xFF00–0xFFFF is I/O.
- R7: After reset the ROM is enabled and the lower half is selected (`rom_addr[12]`=0). For any base below 0xFF, the vector address 0xFFFE then decodes as ROM.
- R8: On a rising `clk` edge, the control register loads `wdata` when all of these hold: `addr_valid`, the I/O page is hit, `cpu_rw`=0, `wr_stb`=1 and `addr[7:0]` equals `CTRL_PORT` (default 0x7F). A write that fails any of these conditions leaves the register unchanged.
- R9: When control bit 0 is 1, addresses above the base assert `ram_sel` instead of `rom_sel`.
- R10: Control bit 1 drives `rom_addr[12]`.
- R11: `io_port` equals `addr[7:0]`. `io_read` is `io_sel` and `cpu_rw`=1. `io_write` is `io_sel` and `cpu_rw`=0. Both strobes are low outside the I/O page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low reset |
| io_base | input | 8 | Base page compared with the upper address byte |
| addr | input | 16 | Processor address |
| addr_valid | input | 1 | Address is valid this cycle |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| wr_stb | input | 1 | Write strobe for the control register |
| wdata | input | 8 | Write data; bit 0 = ROM off, bit 1 = upper half |
| io_sel | output | 1 | I/O page selected |
| rom_sel | output | 1 | On-board ROM selected |
| ram_sel | output | 1 | External RAM selected |
| rom_addr | output | 13 | Physical ROM address |
| io_port | output | 8 | I/O port number |
| io_read | output | 1 | I/O read strobe |
| io_write | output | 1 | I/O write strobe |

## Verification
A write to the control port is also an ordinary I/O-page write, so in one cycle the block must raise `io_write`, show the port number and load its own register. The bench drives such writes with the decode outputs checked in the same cycle. After the clock edge it checks that the new ROM-off and half-select values take effect on the next address. It also drives near-miss writes and checks that they change nothing: a neighbouring port, a read direction, a deasserted valid, and no strobe. For each of these, the bench rechecks a ROM-region address.

// File: rtl/mem_region_decode.sv
module mem_region_decode #(
  parameter int          ADDR_W    = 16,
  parameter int          PORT_W    = 8,
  parameter int          ROM_AW    = 12,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  CTRL_PORT = 8'h7F,
  parameter int          OFF_BIT   = 0,
  parameter int          HALF_BIT  = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-PORT_W-1:0]   io_base,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       addr_valid,
  input  logic                       cpu_rw,
  input  logic                       wr_stb,
  input  logic [DATA_W-1:0]          wdata,
  output logic                       io_sel,
  output logic                       rom_sel,
  output logic                       ram_sel,
  output logic [ROM_AW:0]            rom_addr,
  output logic [PORT_W-1:0]          io_port,
  output logic                       io_read,
  output logic                       io_write
);

  localparam int HI_W = ADDR_W - PORT_W;

  logic [HI_W-1:0] page;
  logic            page_eq, page_gt;
  logic            rom_off, rom_hi;
  logic            ctrl_wr;

  assign page    = addr[ADDR_W-1:PORT_W];
  assign page_eq = (page == io_base);
  assign page_gt = (page > io_base);

  assign io_sel  = addr_valid & page_eq;
  assign rom_sel = addr_valid & page_gt & ~rom_off;
  assign ram_sel = addr_valid & ~page_eq & (~page_gt | rom_off);

  assign rom_addr = {rom_hi, addr[ROM_AW-1:0]};
  assign io_port  = addr[PORT_W-1:0];
  assign io_read  = io_sel & cpu_rw;
  assign io_write = io_sel & ~cpu_rw;

  assign ctrl_wr = io_write & wr_stb & (addr[PORT_W-1:0] == CTRL_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_off <= 1'b0;
      rom_hi  <= 1'b0;
    end else if (ctrl_wr) begin
      rom_off <= wdata[OFF_BIT];
      rom_hi  <= wdata[HALF_BIT];
    end
  end

  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $onehot({io_sel, rom_sel, ram_sel}));

  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> !(io_sel || rom_sel || ram_sel));

  a_r1_io_page: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr[ADDR_W-1:PORT_W] == io_base) |-> io_sel);

  a_r3_below_base: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr[ADDR_W-1:PORT_W] < io_base) |-> ram_sel);

  a_r9_rom_off: assert property (@(posedge clk) disable iff (!rst_n)
    (io_write && wr_stb && io_port == CTRL_PORT && wdata[OFF_BIT]) |=> !rom_sel);

  a_r10_half: assert property (@(posedge clk) disable iff (!rst_n)
    (io_write && wr_stb && io_port == CTRL_PORT) |=> (rom_addr[ROM_AW] == $past(wdata[HALF_BIT])));

  a_r11_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (io_port == addr[PORT_W-1:0]) && (io_read != io_write));

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel |-> !(io_read || io_write));

endmodule

// File: tb/test_mem_region_decode.sv
module test_mem_region_decode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_base = 8'hF8;
  logic [15:0] addr = '0;
  logic        addr_valid = 1'b0;
  logic        cpu_rw = 1'b1;
  logic        wr_stb = 1'b0;
  logic [7:0]  wdata = '0;
  logic        io_sel, rom_sel, ram_sel, io_read, io_write;
  logic [12:0] rom_addr;
  logic [7:0]  io_port;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mem_region_decode i_mem_region_decode (
    .clk(clk), .rst_n(rst_n), .io_base(io_base), .addr(addr),
    .addr_valid(addr_valid), .cpu_rw(cpu_rw), .wr_stb(wr_stb), .wdata(wdata),
    .io_sel(io_sel), .rom_sel(rom_sel), .ram_sel(ram_sel), .rom_addr(rom_addr),
    .io_port(io_port), .io_read(io_read), .io_write(io_write)
  );

  // {base, addr, rw, io, rom, ram, rom_addr}
  localparam int NV = 13;
  localparam logic [40:0] VEC [NV] = '{
    {8'hF8, 16'hF800, 1'b1, 3'b100, 13'h0800},
    {8'hF8, 16'hF8FF, 1'b0, 3'b100, 13'h08FF},
    {8'hF8, 16'hF900, 1'b1, 3'b010, 13'h0900},
    {8'hF8, 16'hFFFF, 1'b1, 3'b010, 13'h0FFF},
    {8'hF8, 16'hF7FF, 1'b0, 3'b001, 13'h07FF},
    {8'h00, 16'h0000, 1'b1, 3'b100, 13'h0000},
    {8'h00, 16'h0100, 1'b1, 3'b010, 13'h0100},
    {8'h00, 16'h8000, 1'b0, 3'b010, 13'h0000},
    {8'hEF, 16'hEF00, 1'b0, 3'b100, 13'h0F00},
    {8'hEF, 16'hF000, 1'b1, 3'b010, 13'h0000},
    {8'hEF, 16'hEEFF, 1'b1, 3'b001, 13'h0EFF},
    {8'hFF, 16'hFFFE, 1'b1, 3'b100, 13'h0FFE},
    {8'hFF, 16'hFEFF, 1'b1, 3'b001, 13'h0EFF}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b, input logic [15:0] a, input logic rw,
                       input logic v, input logic s, input logic [7:0] d);
    @(negedge clk);
    io_base = b; addr = a; cpu_rw = rw; addr_valid = v; wr_stb = s; wdata = d;
    #1;
  endtask

  task automatic sels(input string req, input logic [2:0] exp);
    chk(req, {29'd0, io_sel, rom_sel, ram_sel}, {29'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R4: idle during reset
    repeat (3) @(negedge clk);
    #1;
    sels("R4 reset idle", 3'b000);
    chk("R11 reset strobes", {30'd0, io_read, io_write}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: reset state places ROM, lower half, at the vector
    drive(8'hF8, 16'hFFFE, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R7 vector decodes as ROM", 3'b010);
    chk("R7 lower half after reset", {19'd0, rom_addr}, 32'h0FFE);

    // R1 R2 R3 R5 R6 R11: table
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      drive(v[40:33], v[32:17], v[16], 1'b1, 1'b0, 8'h00);
      sels("R1/R2/R3/R6 region", v[15:13]);
      chk("R5 rom_addr", {19'd0, rom_addr}, {19'd0, v[12:0]});
      chk("R11 io_port", {24'd0, io_port}, {24'd0, v[24:17]});
      chk("R11 strobes", {30'd0, io_read, io_write},
          {30'd0, v[15] & v[16], v[15] & ~v[16]});
    end

    // R4: valid low gives no select
    drive(8'hF8, 16'hF800, 1'b0, 1'b0, 1'b0, 8'h00);
    sels("R4 invalid idle", 3'b000);

    // R8 R9: control write; same cycle is an I/O write
    drive(8'hF8, 16'hF87F, 1'b0, 1'b1, 1'b1, 8'h01);
    sels("R8 control port is I/O", 3'b100);
    chk("R11 io_write on control port", {31'd0, io_write}, 32'd1);
    drive(8'hF8, 16'hF900, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R9 ROM off goes to RAM", 3'b001);
    drive(8'hF8, 16'hFFFE, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R9 ROM off vector", 3'b001);
    drive(8'hF8, 16'hF7FF, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R9 RAM below unaffected", 3'b001);
    drive(8'hF8, 16'hF800, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R9 I/O unaffected", 3'b100);

    // R8: ignored writes (each would re-enable ROM)
    drive(8'hF8, 16'hF87E, 1'b0, 1'b1, 1'b1, 8'h00);
    drive(8'hF8, 16'hF900, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R8 wrong port ignored", 3'b001);
    drive(8'hF8, 16'hF87F, 1'b1, 1'b1, 1'b1, 8'h00);
    drive(8'hF8, 16'hF900, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R8 read ignored", 3'b001);
    drive(8'hF8, 16'hF87F, 1'b0, 1'b0, 1'b1, 8'h00);
    drive(8'hF8, 16'hF900, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R8 invalid ignored", 3'b001);
    drive(8'hF8, 16'hF87F, 1'b0, 1'b1, 1'b0, 8'h00);
    drive(8'hF8, 16'hF900, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R8 no strobe ignored", 3'b001);
    drive(8'hF8, 16'hF97F, 1'b0, 1'b1, 1'b1, 8'h00);
    drive(8'hF8, 16'hF900, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R8 outside I/O page ignored", 3'b001);

    // R10: upper half, ROM enabled
    drive(8'hF8, 16'hF87F, 1'b0, 1'b1, 1'b1, 8'h02);
    drive(8'hF8, 16'hF900, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R10 ROM back on", 3'b010);
    chk("R10 upper half", {19'd0, rom_addr}, 32'h1900);

    // R7: reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'hEF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 8'h00);
    sels("R7 ROM after re-reset", 3'b010);
    chk("R7 lower half after re-reset", {19'd0, rom_addr}, 32'h0FFF);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule